// File: doc/BRIEF.md
# Sleep-Depth and Interrupt-Wake Controller

This block sets the power state of a small processor core from a handful of status-register bits. Five bits of a status word held inside the block matter here: a global interrupt enable, a CPU-halt bit, an oscillator-halt bit and two clock-generator gating bits (a low one and a high one). The combination of set bits selects how deep the core sleeps. The block turns those bits into four clock-enable outputs: the CPU clock, the fast system clock, the clock generator and the slow auxiliary clock.

When an enabled interrupt arrives, all clocks are forced on at once. The block asks the stack logic to save the program counter and the status word, and when that save is acknowledged it clears the halt bits. Return from the handler reloads the status word from the stacked copy. Because the handler may have edited that copy, the core can resume or go into a different sleep depth. The stack memory and the instruction decoder sit outside the block and are reached through simple request and acknowledge pins.

A separate deep-shutdown path drops the core regulator enable, and optionally the real-time-clock domain enable as well. Waking from it is not a resume. The status word is wiped, the core is held in reset while power comes back, and the reset is released on a clock edge a fixed number of cycles after power-good.

Top module: `pwr_mode_top`

## Requirements
- R1: Status bits are gie=bit0, cpuHalt=bit1, oscHalt=bit2, genGate=bit3 and fastGate=bit4. Outside a wake override and outside shutdown, cpuClkEn is the inverse of bit1, auxClkEn the inverse of bit2, genClkEn the inverse of bit3 and fastClkEn the inverse of bit4.
- R2: irqPending equals irqReq AND gie. While the core is running and irqPending is high, all four clock enables are high in the same cycle, whatever the sleep bits are. An enabled interrupt that is pending when a sleep mode is written therefore never lets the clocks gate. A request with gie=0 has no effect.
- R3: One cycle after an enabled interrupt is seen in the running state, pushReq goes high. It stays high until pushAck, with pushPc equal to pcIn and pushSr equal to the current status word.
- R4: At the pushAck edge, bits 1, 2 and 4 are cleared, while bit3 and bit0 keep their values. The handler phase then begins, and no further interrupt is taken until return.
- R5: retiReq in the handler phase loads the status word from stackSr, including any edited value. The block then returns to the running state, where the reloaded bits drive the clock enables.
- R6: srWrEn loads srWrData into the status word in the running and handler phases. It is ignored while a push is outstanding, during shutdown and during wake.
- R7: shutReq in the running state with no enabled interrupt pending enters shutdown on the next cycle. In shutdown, coreLdoEn is low, rtcLdoEn equals the shutKeepRtc value captured with the request, all clock enables are low and coreRstN is low. An enabled interrupt has priority over shutReq.
- R8: wakeEvt in shutdown raises both regulator enables on the next cycle, keeps coreRstN low and clears the status word to zero.
- R9: In wake, coreRstN rises on the edge that completes RST_HOLD consecutive sampled cycles of pwrGood high. A low pwrGood restarts the count.
- R10: After reset, the status word is 0, all clock and regulator enables are high, coreRstN is high and pushReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srWrEn | input | 1 | Software write strobe for the status word |
| srWrData | input | SR_W | Value to write into the status word |
| irqReq | input | 1 | Combined peripheral interrupt request |
| pcIn | input | PC_W | Current program counter |
| pushAck | input | 1 | Stack logic has saved the program counter and status word |
| retiReq | input | 1 | Decoder signals return from interrupt |
| stackSr | input | SR_W | Stacked status word presented on return |
| shutReq | input | 1 | Request for deep shutdown |
| shutKeepRtc | input | 1 | 1 keeps the RTC domain powered in shutdown |
| wakeEvt | input | 1 | Wake event from shutdown |
| pwrGood | input | 1 | Core supply is valid |
| srOut | output | SR_W | Current status word |
| irqPending | output | 1 | Enabled interrupt is pending |
| pushReq | output | 1 | Request to stack the program counter and status word |
| pushPc | output | PC_W | Program counter to stack |
| pushSr | output | SR_W | Status word to stack |
| cpuClkEn | output | 1 | CPU clock enable |
| fastClkEn | output | 1 | Fast system clock enable |
| genClkEn | output | 1 | Clock generator enable |
| auxClkEn | output | 1 | Slow auxiliary clock enable |
| coreLdoEn | output | 1 | Core regulator enable |
| rtcLdoEn | output | 1 | RTC domain regulator enable |
| coreRstN | output | 1 | Active-low core reset |

## Verification
The in-RTL properties check on every cycle several rules that hold in any situation. Bits 1, 2 and 4 must be clear right after a push acknowledge, with bit3 unchanged. The status word must be zero right after a wake. An enabled interrupt in the running state must lead to a push request. A shutdown request must drop the core regulator and hold reset. Core reset may only be released after a sampled power-good. What only the bench scenarios show is the shape of whole sequences: that an edited stacked word picks the sleep depth after return, that a software write during an outstanding push is lost, that a power-good glitch restarts the reset hold, and that an interrupt pending at sleep entry keeps every clock running.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int GIE_B   = 0;
  localparam int CPUH_B  = 1;
  localparam int OSCH_B  = 2;
  localparam int GENG_B  = 3;
  localparam int FASTG_B = 4;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_PUSH = 3'd1,
    ST_HAND = 3'd2,
    ST_SHUT = 3'd3,
    ST_WAKE = 3'd4
  } pmState_e;

  typedef struct packed {
    logic takeIrq;
    logic doReti;
    logic srClear;
    logic wrOk;
    logic wakeOvr;
    logic gateAll;
  } pmStrobe_t;
endpackage

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqReq,
  input  logic      gie,
  input  logic      pushAck,
  input  logic      retiReq,
  input  logic      shutReq,
  input  logic      shutKeepRtc,
  input  logic      wakeEvt,
  input  logic      pwrGood,
  output pmStrobe_t stb,
  output logic      pushReq,
  output logic      coreLdoEn,
  output logic      rtcLdoEn,
  output logic      coreRstN
);
  localparam int CNT_W = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);

  pmState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic keepQ, keepD;
  logic irqTake;

  assign irqTake = irqReq && gie;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    keepD  = keepQ;
    stb    = '0;
    unique case (stateQ)
      ST_RUN: begin
        stb.wrOk    = 1'b1;
        stb.wakeOvr = irqTake;
        if (irqTake) stateD = ST_PUSH;
        else if (shutReq) begin
          stateD = ST_SHUT;
          keepD  = shutKeepRtc;
        end
      end
      ST_PUSH: begin
        stb.wakeOvr = 1'b1;
        if (pushAck) begin
          stb.takeIrq = 1'b1;
          stateD      = ST_HAND;
        end
      end
      ST_HAND: begin
        if (retiReq) begin
          stb.doReti = 1'b1;
          stateD     = ST_RUN;
        end else begin
          stb.wrOk = 1'b1;
        end
      end
      ST_SHUT: begin
        stb.gateAll = 1'b1;
        if (wakeEvt) begin
          stb.srClear = 1'b1;
          stateD      = ST_WAKE;
          cntD        = '0;
        end
      end
      ST_WAKE: begin
        stb.gateAll = 1'b1;
        if (!pwrGood) cntD = '0;
        else if (cntQ == HOLD_LAST) begin
          cntD   = '0;
          stateD = ST_RUN;
        end else cntD = cntQ + 1'b1;
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_RUN;
      cntQ   <= '0;
      keepQ  <= 1'b1;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      keepQ  <= keepD;
    end
  end

  assign pushReq   = (stateQ == ST_PUSH);
  assign coreLdoEn = (stateQ != ST_SHUT);
  assign rtcLdoEn  = (stateQ != ST_SHUT) || keepQ;
  assign coreRstN  = (stateQ != ST_SHUT) && (stateQ != ST_WAKE);

  // R3
  irq_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && irqReq && gie) |=> pushReq);

  // R7
  shut_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && shutReq && !(irqReq && gie)) |=> (!coreLdoEn && !coreRstN));

  // R9
  rst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstN) |-> $past(pwrGood));
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  pmStrobe_t       stb,
  input  logic            srWrEn,
  input  logic [SR_W-1:0] srWrData,
  input  logic [SR_W-1:0] stackSr,
  output logic [SR_W-1:0] srQ,
  output logic            cpuClkEn,
  output logic            fastClkEn,
  output logic            genClkEn,
  output logic            auxClkEn
);
  localparam logic [SR_W-1:0] WAKE_CLR =
    (SR_W'(1) << CPUH_B) | (SR_W'(1) << OSCH_B) | (SR_W'(1) << FASTG_B);

  logic [SR_W-1:0] srD;

  always_comb begin
    srD = srQ;
    if (stb.srClear)                srD = '0;
    else if (stb.doReti)            srD = stackSr;
    else if (stb.takeIrq)           srD = srQ & ~WAKE_CLR;
    else if (stb.wrOk && srWrEn)    srD = srWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srQ <= '0;
    else       srQ <= srD;
  end

  always_comb begin
    if (stb.gateAll) begin
      {cpuClkEn, fastClkEn, genClkEn, auxClkEn} = 4'b0000;
    end else if (stb.wakeOvr) begin
      {cpuClkEn, fastClkEn, genClkEn, auxClkEn} = 4'b1111;
    end else begin
      cpuClkEn  = !srQ[CPUH_B];
      fastClkEn = !srQ[FASTG_B];
      genClkEn  = !srQ[GENG_B];
      auxClkEn  = !srQ[OSCH_B];
    end
  end

  // R4
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeIrq |=> (!srQ[CPUH_B] && !srQ[OSCH_B] && !srQ[FASTG_B]
                     && srQ[GENG_B] == $past(srQ[GENG_B])));

  // R8
  wake_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.srClear |=> (srQ == '0));
endmodule

// File: rtl/pwr_mode_top.sv
module pwr_mode_top
  import pwr_mode_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int SR_W     = 8,
  parameter int RST_HOLD = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            srWrEn,
  input  logic [SR_W-1:0] srWrData,
  input  logic            irqReq,
  input  logic [PC_W-1:0] pcIn,
  input  logic            pushAck,
  input  logic            retiReq,
  input  logic [SR_W-1:0] stackSr,
  input  logic            shutReq,
  input  logic            shutKeepRtc,
  input  logic            wakeEvt,
  input  logic            pwrGood,
  output logic [SR_W-1:0] srOut,
  output logic            irqPending,
  output logic            pushReq,
  output logic [PC_W-1:0] pushPc,
  output logic [SR_W-1:0] pushSr,
  output logic            cpuClkEn,
  output logic            fastClkEn,
  output logic            genClkEn,
  output logic            auxClkEn,
  output logic            coreLdoEn,
  output logic            rtcLdoEn,
  output logic            coreRstN
);
  pmStrobe_t stb;
  logic [SR_W-1:0] srQ;

  pwr_mode_ctl #(.RST_HOLD(RST_HOLD)) uCtl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .gie(srQ[GIE_B]),
    .pushAck(pushAck), .retiReq(retiReq), .shutReq(shutReq),
    .shutKeepRtc(shutKeepRtc), .wakeEvt(wakeEvt), .pwrGood(pwrGood),
    .stb(stb), .pushReq(pushReq), .coreLdoEn(coreLdoEn),
    .rtcLdoEn(rtcLdoEn), .coreRstN(coreRstN)
  );

  pwr_mode_dp #(.SR_W(SR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .srWrEn(srWrEn),
    .srWrData(srWrData), .stackSr(stackSr), .srQ(srQ),
    .cpuClkEn(cpuClkEn), .fastClkEn(fastClkEn),
    .genClkEn(genClkEn), .auxClkEn(auxClkEn)
  );

  assign srOut      = srQ;
  assign irqPending = irqReq && srQ[GIE_B];
  assign pushPc     = pcIn;
  assign pushSr     = srQ;
endmodule

// File: tb/sim_pwr_mode_top.sv
module sim_pwr_mode_top;
  localparam int PERIOD = 10;
  localparam int PC_W = 16;
  localparam int SR_W = 8;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic srWrEn = 0, irqReq = 0, pushAck = 0, retiReq = 0;
  logic shutReq = 0, shutKeepRtc = 0, wakeEvt = 0, pwrGood = 0;
  logic [SR_W-1:0] srWrData = '0, stackSr = '0;
  logic [PC_W-1:0] pcIn = 16'h1234;
  logic [SR_W-1:0] srOut, pushSr;
  logic [PC_W-1:0] pushPc;
  logic irqPending, pushReq, cpuClkEn, fastClkEn, genClkEn, auxClkEn;
  logic coreLdoEn, rtcLdoEn, coreRstN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference: 0 run, 1 push, 2 handler, 3 shutdown, 4 wake
  int mMode = 0;
  int mCnt = 0;
  bit mKeep = 1;
  logic [SR_W-1:0] mSr = '0;

  always #(PERIOD/2) clk = ~clk;

  pwr_mode_top #(.PC_W(PC_W), .SR_W(SR_W), .RST_HOLD(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .srWrEn(srWrEn), .srWrData(srWrData),
    .irqReq(irqReq), .pcIn(pcIn), .pushAck(pushAck), .retiReq(retiReq),
    .stackSr(stackSr), .shutReq(shutReq), .shutKeepRtc(shutKeepRtc),
    .wakeEvt(wakeEvt), .pwrGood(pwrGood), .srOut(srOut),
    .irqPending(irqPending), .pushReq(pushReq), .pushPc(pushPc),
    .pushSr(pushSr), .cpuClkEn(cpuClkEn), .fastClkEn(fastClkEn),
    .genClkEn(genClkEn), .auxClkEn(auxClkEn), .coreLdoEn(coreLdoEn),
    .rtcLdoEn(rtcLdoEn), .coreRstN(coreRstN)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mKeep = 1; mSr = '0;
    end else begin
      case (mMode)
        0: begin
          if (srWrEn) mSr = srWrData;
          if (irqReq && u0_gie()) mMode = 1;
          else if (shutReq) begin mKeep = shutKeepRtc; mMode = 3; end
        end
        1: if (pushAck) begin mSr = mSr & 8'hE9; mMode = 2; end
        2: begin
          if (retiReq) begin mSr = stackSr; mMode = 0; end
          else if (srWrEn) mSr = srWrData;
        end
        3: if (wakeEvt) begin mSr = '0; mCnt = 0; mMode = 4; end
        default: begin
          if (!pwrGood) mCnt = 0;
          else if (mCnt == HOLD - 1) begin mCnt = 0; mMode = 0; end
          else mCnt++;
        end
      endcase
    end
  end

  // gie seen by the reference before its own update this cycle
  logic gieSnap;
  function automatic bit u0_gie();
    return gieSnap;
  endfunction
  always @(negedge clk) gieSnap = mSr[0];

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit ovr, gate;
      ovr  = (mMode == 1) || (mMode == 0 && irqReq && mSr[0]);
      gate = (mMode >= 3);
      chk("R6", "srOut", srOut, mSr);
      chk("R2", "irqPending", irqPending, irqReq && mSr[0]);
      chk("R3", "pushReq", pushReq, mMode == 1);
      if (mMode == 1) begin
        chk("R3", "pushPc", pushPc, pcIn);
        chk("R3", "pushSr", pushSr, mSr);
      end
      chk("R1", "cpuClkEn", cpuClkEn, gate ? 0 : (ovr ? 1 : !mSr[1]));
      chk("R1", "auxClkEn", auxClkEn, gate ? 0 : (ovr ? 1 : !mSr[2]));
      chk("R1", "genClkEn", genClkEn, gate ? 0 : (ovr ? 1 : !mSr[3]));
      chk("R1", "fastClkEn", fastClkEn, gate ? 0 : (ovr ? 1 : !mSr[4]));
      chk("R7", "coreLdoEn", coreLdoEn, mMode != 3);
      chk("R7", "rtcLdoEn", rtcLdoEn, (mMode != 3) || mKeep);
      chk("R9", "coreRstN", coreRstN, mMode < 3);
    end
  end

  task automatic nxt(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wrSr(input logic [SR_W-1:0] v);
    srWrEn = 1; srWrData = v;
    nxt(1);
    srWrEn = 0;
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD*2 + 3);
    // R10 reset state
    chk("R10", "srOut", srOut, 0);
    chk("R10", "clkEns", {cpuClkEn, fastClkEn, genClkEn, auxClkEn}, 4'hF);
    chk("R10", "ldo/rst", {coreLdoEn, rtcLdoEn, coreRstN, pushReq}, 4'b1110);
    rstN = 1;
    nxt(1);

    // sleep depths: mode 0, mode 3, mode 4
    wrSr(8'h03); nxt(2);
    chk("R1", "mode0 cpu off", {cpuClkEn, fastClkEn, genClkEn, auxClkEn}, 4'b0111);
    wrSr(8'h1B); nxt(2);
    chk("R1", "mode3", {cpuClkEn, fastClkEn, genClkEn, auxClkEn}, 4'b0001);
    wrSr(8'h1F); nxt(2);

    // disabled interrupt is ignored
    wrSr(8'h1E); irqReq = 1; nxt(3);
    chk("R2", "gie=0 no push", {pushReq, irqPending, cpuClkEn}, 3'b000);
    irqReq = 0; nxt(1);

    // enabled interrupt from mode 3, software write during push is lost
    wrSr(8'h1B); nxt(1);
    pcIn = 16'hBEEF; irqReq = 1;
    #1 chk("R2", "override same cycle", {cpuClkEn, fastClkEn, genClkEn, auxClkEn}, 4'hF);
    nxt(1);
    chk("R3", "pushSr", pushSr, 8'h1B);
    srWrEn = 1; srWrData = 8'hFF; nxt(1); srWrEn = 0;
    chk("R6", "write ignored in push", srOut, 8'h1B);
    pushAck = 1; nxt(1); pushAck = 0;
    chk("R4", "bits cleared, genGate kept", srOut, 8'h09);
    nxt(3);
    chk("R4", "no re-entry", pushReq, 0);
    irqReq = 0;
    wrSr(8'h0B); nxt(1);
    chk("R6", "handler write", srOut, 8'h0B);
    stackSr = 8'h1B; retiReq = 1; nxt(1); retiReq = 0;
    chk("R5", "restored mode3", srOut, 8'h1B);
    nxt(1);

    // edited stacked word returns to active
    irqReq = 1; nxt(1); pushAck = 1; nxt(1); pushAck = 0; irqReq = 0;
    stackSr = 8'h01; retiReq = 1; nxt(1); retiReq = 0;
    chk("R5", "edited return active", {cpuClkEn, fastClkEn, genClkEn, auxClkEn}, 4'hF);

    // pending interrupt when sleep is written keeps clocks running
    irqReq = 1; srWrEn = 1; srWrData = 8'h1F;
    #1 chk("R2", "pending at entry", cpuClkEn, 1);
    nxt(1); srWrEn = 0;
    pushAck = 1; nxt(1); pushAck = 0; irqReq = 0;
    stackSr = 8'h01; retiReq = 1; nxt(1); retiReq = 0;

    // interrupt wins over shutdown
    irqReq = 1; shutReq = 1; nxt(1); shutReq = 0;
    chk("R7", "irq priority", {pushReq, coreLdoEn}, 2'b11);
    pushAck = 1; nxt(1); pushAck = 0; irqReq = 0;
    stackSr = 8'h01; retiReq = 1; nxt(1); retiReq = 0;

    // shutdown keeping RTC domain, glitchy power-good
    shutKeepRtc = 1; shutReq = 1; nxt(1); shutReq = 0; shutKeepRtc = 0;
    chk("R7", "keep rtc", {coreLdoEn, rtcLdoEn, coreRstN}, 3'b010);
    nxt(2);
    wakeEvt = 1; nxt(1); wakeEvt = 0;
    chk("R8", "wake wipe", {srOut, coreLdoEn, rtcLdoEn, coreRstN}, {8'h00, 3'b110});
    pwrGood = 1; nxt(2); pwrGood = 0; nxt(1); pwrGood = 1;
    nxt(HOLD - 1);
    chk("R9", "still held", coreRstN, 0);
    nxt(1);
    chk("R9", "released", coreRstN, 1);

    // deepest shutdown
    wrSr(8'h05);
    shutKeepRtc = 0; shutReq = 1; nxt(1); shutReq = 0;
    chk("R7", "both off", {coreLdoEn, rtcLdoEn}, 2'b00);
    srWrEn = 1; srWrData = 8'h1F; nxt(1); srWrEn = 0;
    wakeEvt = 1; nxt(1); wakeEvt = 0;
    chk("R8", "wiped after deep", srOut, 0);
    nxt(HOLD + 2);
    chk("R9", "running again", coreRstN, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule